// File: doc/BRIEF.md
# Microcode Command Latch and Bus Direction Control

This block sits beside a microcoded execution engine. Once per machine cycle it captures a 3-bit command field from the microcode word. When the command is enabled, it turns the field into a one-clock, one-hot control strobe. The eight strobe lines feed the fault register, the internal DMA logic, a coprocessor discrete and the interrupt vector selector; those destinations are outside this block. The block also drives the active-low bus data-direction output.

Everything runs on a free-running oscillator clock. The machine-cycle clock arrives as a level synchronous to that oscillator, and its high-to-low transition marks the capture point. While DMA or hold is acknowledged, capture and decode are suppressed. The last captured command then stays in effect.

The two upper bits of the captured field select the direction behaviour in memory cycles:
- When both bits are high, the cycle is a write, and the direction output is held high for the whole cycle.
- Otherwise, the direction output is the data strobe delayed by one oscillator clock.

In internal cycles both the data strobe and the memory/I/O select sit high, so the direction output stays high. There is no streaming data path, so every pin is a plain control level.

Top module: `mcl_cmd_dir`

## Requirements
- R1: After reset, all eight strobes are low and `dir_n` is high. The held command resets to 000, which is a non-write encoding, so `dir_n` then follows the delayed data strobe.
- R2: A capture point is an oscillator edge at which `cyc_clk` is sampled low after having been sampled high at the previous edge. Any resulting strobe is high during the oscillator cycle that follows that edge.
- R3: A strobe is produced only when `int_en_n` is low at the capture point. Strobe bit k (k = 0..7) is raised exactly when the field value is k. With `int_en_n` high, all strobes stay low.
- R4: At a capture point where `dma_ack_n` or `hold_ack_n` is low, no strobe is produced and the held command is not updated. The previous command keeps controlling `dir_n`.
- R5: While `mem_sel` is high and the held field has bits [2:1] = 11 (a write), `dir_n` is high on the next clock, whatever `dstrb_n` does.
- R6: In all other cases, `dir_n` equals the value `dstrb_n` had one oscillator clock earlier. This includes I/O cycles (`mem_sel` low) and any held field with bit 2 or bit 1 low.
- R7: At most one strobe bit is high at any time, and no strobe stays high for more than one oscillator clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_clk | input | 1 | Machine-cycle clock level; a high-to-low change marks capture |
| mc_field | input | 3 | Microcode command field |
| int_en_n | input | 1 | Decode enable, active low |
| dstrb_n | input | 1 | Data strobe, active low |
| mem_sel | input | 1 | High for a memory cycle, low for I/O |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| hold_ack_n | input | 1 | Hold acknowledge, active low |
| dir_n | output | 1 | Bus data-direction output |
| ctl_strb | output | 8 | One-hot command strobes, bit index = field value |

## Verification
Timing of each result relative to its stimulus:
- A strobe is due one oscillator clock after the edge that first samples `cyc_clk` low, and it lasts one clock.
- `dir_n` is due one clock after `dstrb_n` changes.
- A newly captured write field takes effect on `dir_n` one clock after the capture point. The clock that coincides with the capture still uses the previous field.

The bench drives inputs on falling oscillator edges and updates a behavioural model on each rising edge with the same sampled inputs. It compares both outputs against the model at the next falling edge, so every check lands exactly where these latencies put the result. Directed machine cycles start the write strobe one clock after capture, so that the held-high behaviour can be seen over the whole cycle.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
  localparam int unsigned MCL_FIELD_W = 3;
  localparam int unsigned MCL_MODE_W  = 2;

  typedef enum logic {
    DIR_TO_BUS  = 1'b0,
    DIR_FROM_BUS = 1'b1
  } dir_e;

  function automatic logic mode_is_write(input logic [MCL_MODE_W-1:0] mode);
    return &mode;
  endfunction
endpackage

// File: rtl/mcl_edge_det.sv
module mcl_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_in;
  end

  assign fall = lvl_q & ~lvl_in;

  // R2: two consecutive capture points are impossible
  a_r2_no_double_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/mcl_field_latch.sv
module mcl_field_latch #(
  parameter int unsigned FIELD_W = mcl_pkg::MCL_FIELD_W,
  parameter int unsigned MODE_W  = mcl_pkg::MCL_MODE_W,
  localparam int unsigned STRB_W = 1 << FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_edge,
  input  logic [FIELD_W-1:0] field_in,
  input  logic               dec_en_n,
  input  logic               dma_ack_n,
  input  logic               hold_ack_n,
  output logic [MODE_W-1:0]  mode_q,
  output logic [STRB_W-1:0]  strb
);
  logic              gate_open;
  logic              take;
  logic              fire;
  logic [STRB_W-1:0] strb_d;

  assign gate_open = dma_ack_n & hold_ack_n;
  assign take      = cap_edge & gate_open;
  assign fire      = take & ~dec_en_n;

  for (genvar k = 0; k < STRB_W; k++) begin : g_dec
    assign strb_d[k] = fire && (field_in == FIELD_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb   <= '0;
      mode_q <= '0;
    end else begin
      strb <= strb_d;
      if (take) mode_q <= field_in[FIELD_W-1 -: MODE_W];
    end
  end

  // R7
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));
  a_r7_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb != '0) |=> (strb == '0));
  // R3
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_edge && dec_en_n) |=> (strb == '0));
  a_r3_decode_index: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_edge && gate_open && !dec_en_n) |=> (strb == (STRB_W'(1) << $past(field_in))));
  // R4
  a_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_edge && !gate_open) |=> ($stable(mode_q) && strb == '0));
endmodule

// File: rtl/mcl_dir_ctrl.sv
module mcl_dir_ctrl #(
  parameter int unsigned MODE_W = mcl_pkg::MCL_MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              mem_sel,
  input  logic              dstrb_n,
  output logic              dir_n
);
  import mcl_pkg::*;

  logic hold_high;
  dir_e dir_q;

  assign hold_high = mem_sel & mode_is_write(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dir_q <= DIR_FROM_BUS;
    else if (hold_high) dir_q <= DIR_FROM_BUS;
    else                dir_q <= dir_e'(dstrb_n);
  end

  assign dir_n = dir_q;

  // R5
  a_r5_write_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel && (&mode_q)) |=> dir_n);
  // R6
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_sel && (&mode_q)) |=> (dir_n == $past(dstrb_n)));
endmodule

// File: rtl/mcl_cmd_dir.sv
module mcl_cmd_dir #(
  parameter int unsigned FIELD_W = mcl_pkg::MCL_FIELD_W,
  localparam int unsigned MODE_W = mcl_pkg::MCL_MODE_W,
  localparam int unsigned STRB_W = 1 << FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_clk,
  input  logic [FIELD_W-1:0] mc_field,
  input  logic               int_en_n,
  input  logic               dstrb_n,
  input  logic               mem_sel,
  input  logic               dma_ack_n,
  input  logic               hold_ack_n,
  output logic               dir_n,
  output logic [STRB_W-1:0]  ctl_strb
);
  logic              cap_edge;
  logic [MODE_W-1:0] mode_q;

  mcl_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (cyc_clk),
    .fall   (cap_edge)
  );

  mcl_field_latch #(.FIELD_W(FIELD_W), .MODE_W(MODE_W)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_edge   (cap_edge),
    .field_in   (mc_field),
    .dec_en_n   (int_en_n),
    .dma_ack_n  (dma_ack_n),
    .hold_ack_n (hold_ack_n),
    .mode_q     (mode_q),
    .strb       (ctl_strb)
  );

  mcl_dir_ctrl #(.MODE_W(MODE_W)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_q  (mode_q),
    .mem_sel (mem_sel),
    .dstrb_n (dstrb_n),
    .dir_n   (dir_n)
  );

  // R1: nothing strobes in the first clock after reset release
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctl_strb == '0));
endmodule

// File: tb/mcl_cmd_dir_tb_top.sv
`timescale 1ns/1ps
module mcl_cmd_dir_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_clk = 1'b0;
  logic [2:0] mc_field = 3'd0;
  logic int_en_n = 1'b1;
  logic dstrb_n = 1'b1;
  logic mem_sel = 1'b1;
  logic dma_ack_n = 1'b1;
  logic hold_ack_n = 1'b1;
  logic dir_n;
  logic [7:0] ctl_strb;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural reference state
  bit       m_prev_cyc;
  bit [2:0] m_held;
  bit       m_dir;
  bit [7:0] m_strb;

  always #5 clk = ~clk;

  mcl_cmd_dir dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_clk(cyc_clk), .mc_field(mc_field),
    .int_en_n(int_en_n), .dstrb_n(dstrb_n), .mem_sel(mem_sel),
    .dma_ack_n(dma_ack_n), .hold_ack_n(hold_ack_n),
    .dir_n(dir_n), .ctl_strb(ctl_strb)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev_cyc <= 1'b0; m_held <= 3'd0; m_dir <= 1'b1; m_strb <= 8'h00;
    end else begin
      bit cap, open;
      cap  = m_prev_cyc && !cyc_clk;
      open = dma_ack_n && hold_ack_n;
      m_prev_cyc <= cyc_clk;
      m_strb <= (cap && open && !int_en_n) ? (8'h01 << mc_field) : 8'h00;
      if (cap && open) m_held <= mc_field;
      m_dir <= (mem_sel && m_held[2] && m_held[1]) ? 1'b1 : dstrb_n;
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (ctl_strb !== m_strb) begin
      n_bad++;
      $display("FAIL %s strobe: got %h expected %h", tag, ctl_strb, m_strb);
    end
    n_cmp++;
    if (dir_n !== m_dir) begin
      n_bad++;
      $display("FAIL %s direction: got %b expected %b", tag, dir_n, m_dir);
    end
    n_cmp++;
    if ($countones(ctl_strb) > 1) begin
      n_bad++;
      $display("FAIL R7 onehot: got %h expected at most one bit", ctl_strb);
    end
  endtask

  // one six-clock machine cycle; strobe low on clocks 4 and 5 when ds is set
  task automatic mcycle(input bit [2:0] f, input bit en_n, input bit dma_n,
                        input bit hold_n, input bit mem, input bit ds);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      compare();
      cyc_clk = (i < 3);
      mc_field = f; int_en_n = en_n; dma_ack_n = dma_n; hold_ack_n = hold_n;
      mem_sel = mem;
      dstrb_n = !(ds && i >= 4);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    n_cmp++;
    if (ctl_strb !== 8'h00 || dir_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset: got strb %h dir %b expected 00 1", ctl_strb, dir_n);
    end
    mcycle(3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    tag = "R2 R3 R6 read decode";
    for (int f = 0; f < 8; f++) mcycle(3'(f), 1'b0, 1'b1, 1'b1, 1'b1, (f < 6));
    tag = "R5 write held high";
    mcycle(3'd6, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    mcycle(3'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    tag = "R6 io follows strobe";
    mcycle(3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    tag = "R3 decode disabled";
    for (int f = 0; f < 8; f++) mcycle(3'(f), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    tag = "R4 blocked keeps write";
    mcycle(3'd7, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    mcycle(3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    mcycle(3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    tag = "R6 after unblock";
    mcycle(3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    mcycle(3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    tag = "R6 internal cycle";
    mcycle(3'd4, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    tag = "R2 R3 R4 R5 R6 R7 random";
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      compare();
      cyc_clk    = $urandom_range(0, 1);
      mc_field   = 3'($urandom_range(0, 7));
      int_en_n   = ($urandom_range(0, 3) == 0);
      dma_ack_n  = ($urandom_range(0, 5) != 0);
      hold_ack_n = ($urandom_range(0, 5) != 0);
      mem_sel    = ($urandom_range(0, 3) != 0);
      dstrb_n    = $urandom_range(0, 1);
    end
    @(negedge clk);
    compare();
    finish_up();
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end
endmodule